// File: doc/BRIEF.md
# Cascaded Three-Counter Wakeup Timer

This block keeps time on a slow always-on clock (nominally 32.768 kHz) so that a sleeping system can be woken after a programmed number of ticks. It holds two 16-bit match counters, a low counter and a high counter, and one wide free-running stamp counter. The low counter advances on every enabled tick and compares against its own match register. Chaining can be turned on. In that mode the high counter steps once for every low-counter match, and it does not step on low-counter rollover. The two counters then form a 32-bit delay, with the low counter as the lower half. With clear-on-match off, the low counter runs on past its match value, so software sets relative deadlines by adding an offset to the current counts. The stamp counter never stops while it is enabled, and software reads it as the current tick count.

The chain step is not applied in the same tick as the match. A two-state queue, `wkt_chain_e`, holds it for one tick. In state CQ_IDLE, a chained low-counter match takes the QUEUE transition to CQ_QUEUED. In CQ_QUEUED, the high counter steps, and the LAND transition returns to CQ_IDLE unless another chained match in that same tick takes the REQUEUE transition and stays in CQ_QUEUED. A counter-zero command drops any queued step, because it suppresses every match in its tick. Each counter raises an event. The sticky flags latch these events when that counter's interrupt enable is set. A mask selects which flags drive the single interrupt output. A write port on the slow clock programs the block, and the counts and flags come out directly as outputs.

Top module: `wkt_top`

## Requirements
- R1: After `rst_n` is low, all three counters read zero, the flags and `irq` are zero, the control and mask registers are zero, and both match registers read all ones.
- R2: A write with `wr_en` high updates, at that clock edge, the register chosen by `wr_addr`. The address map is: 0 low match; 1 high match; 2 control; 3 interrupt mask (bits 2:0); 4 flag clear (write-one-to-clear, bits 2:0); 5 counter-zero command (data ignored). Control bits are: 0, 1, 2 enable the low, high and stamp counters; 3, 4 set clear-on-match for the low and high counters; 5, 6, 7 set the interrupt enable for the low, high and stamp counters; 8 turns chaining on. Addresses 6 and 7 change nothing.
- R3: An enabled low counter adds one per clock. At every edge where it equals its match value, it raises a low event. With clear-on-match off, it runs past the match and wraps from 0xFFFF to 0.
- R4: With low clear-on-match on, the low counter becomes 0 at an edge where it equals its match value, and the low event is still raised.
- R5: With chaining on, the high counter steps only at the edge that follows an edge where the low counter equalled its match value, and never on low-counter wrap.
- R6: With chaining off, an enabled high counter steps every clock. In either mode, a step raises the high event when the value it produces equals the high match. With high clear-on-match on, a step taken from the match value goes to 0 instead.
- R7: An enabled stamp counter adds one per clock, rolls from all ones to 0, and raises the stamp event on that rollover. Its width is the parameter `STAMP_W` (default 32).
- R8: A disabled counter holds its value and raises no event. A disabled low counter queues no chain step, and a queued step is dropped if the high counter is disabled when it lands.
- R9: A flag sets at the edge where its counter's event occurs with its interrupt enable on. It then stays set until a flag-clear write names it. If a set and a clear fall on the same edge, the set wins.
- R10: `irq` is high exactly when some flag is set and its mask bit is set.
- R11: A counter-zero command clears all three counters and any queued chain step at that edge, and suppresses counting and events in that cycle. A match-register write is first used by the comparison at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| cnt_lo | output | CNT_W | Low counter value |
| cnt_hi | output | CNT_W | High counter value |
| cnt_stamp | output | STAMP_W | Stamp counter value |
| irq_flags | output | 3 | Sticky flags: bit 0 low, bit 1 high, bit 2 stamp |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench checks that the high counter lands exactly one tick after the low match. A design that stepped in the match tick, or stepped on low wrap, would raise the high flag one or many thousands of ticks off. It checks that the low counter runs past its match and wraps at 0xFFFF, which a design that cleared or stuck at the match would miss. It checks that high clear-on-match produces the match value once and only then returns to zero, and that the stamp event fires only on rollover. It also covers a flag set and cleared on the same edge, masking, and the counter-zero command hitting a queued chain step, all of which a wrong priority or a leftover queue entry would break.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    typedef enum logic [2:0] {
        WA_MATCH_LO = 3'd0,
        WA_MATCH_HI = 3'd1,
        WA_CTRL     = 3'd2,
        WA_MASK     = 3'd3,
        WA_FCLR     = 3'd4,
        WA_ZERO     = 3'd5
    } wkt_addr_e;

    typedef struct packed {
        logic chain;
        logic ie2;
        logic ie1;
        logic ie0;
        logic clr1;
        logic clr0;
        logic en2;
        logic en1;
        logic en0;
    } wkt_ctrl_t;

    typedef enum logic {
        CQ_IDLE   = 1'b0,
        CQ_QUEUED = 1'b1
    } wkt_chain_e;

    localparam int NUM_CNT = 3;
    localparam int CTRL_W  = $bits(wkt_ctrl_t);

endpackage

// File: rtl/wkt_regs.sv
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   match_lo,
    output logic [CNT_W-1:0]   match_hi,
    output wkt_ctrl_t          ctrl,
    output logic [NUM_CNT-1:0] irq_mask,
    output logic [NUM_CNT-1:0] flag_clr,
    output logic               zero_cmd
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_lo <= '1;
            match_hi <= '1;
            ctrl     <= '0;
            irq_mask <= '0;
        end else if (wr_en) begin
            case (wkt_addr_e'(wr_addr))
                WA_MATCH_LO: match_lo <= wr_data;
                WA_MATCH_HI: match_hi <= wr_data;
                WA_CTRL:     ctrl     <= wkt_ctrl_t'(wr_data[CTRL_W-1:0]);
                WA_MASK:     irq_mask <= wr_data[NUM_CNT-1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        flag_clr = '0;
        zero_cmd = 1'b0;
        if (wr_en && (wr_addr == WA_FCLR)) flag_clr = wr_data[NUM_CNT-1:0];
        if (wr_en && (wr_addr == WA_ZERO)) zero_cmd = 1'b1;
    end

    // R2: control only changes through its own address
    a_r2_ctrl_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == WA_CTRL)) |=> $stable(ctrl));

endmodule

// File: rtl/wkt_pair.sv
module wkt_pair
    import wkt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_cmd,
    input  logic             en_lo,
    input  logic             en_hi,
    input  logic             clr_lo,
    input  logic             clr_hi,
    input  logic             chain,
    input  logic [CNT_W-1:0] match_lo,
    input  logic [CNT_W-1:0] match_hi,
    output logic [CNT_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] cnt_hi,
    output logic             hit_lo,
    output logic             hit_hi
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wkt_chain_e       state_q, state_d;
    logic             pend;
    logic             adv_hi;
    logic [CNT_W-1:0] step_hi;
    logic [CNT_W-1:0] lo_d, hi_d;

    // chain queue: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CQ_IDLE;
        else        state_q <= state_d;
    end

    // chain queue: next state and output
    always_comb begin
        state_d = CQ_IDLE;
        pend    = 1'b0;
        unique case (state_q)
            CQ_IDLE: begin
                pend = 1'b0;
                if (hit_lo && chain) state_d = CQ_QUEUED;   // QUEUE
            end
            CQ_QUEUED: begin
                pend = 1'b1;                                // LAND
                if (hit_lo && chain) state_d = CQ_QUEUED;   // REQUEUE
            end
        endcase
    end

    always_comb begin
        hit_lo  = en_lo && !zero_cmd && (cnt_lo == match_lo);
        lo_d    = cnt_lo;
        if (zero_cmd)    lo_d = '0;
        else if (en_lo)  lo_d = (hit_lo && clr_lo) ? '0 : cnt_lo + ONE;

        adv_hi  = !zero_cmd && en_hi && (chain ? pend : 1'b1);
        step_hi = (clr_hi && (cnt_hi == match_hi)) ? '0 : cnt_hi + ONE;
        hit_hi  = adv_hi && (step_hi == match_hi);
        hi_d    = cnt_hi;
        if (zero_cmd)    hi_d = '0;
        else if (adv_hi) hi_d = step_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            cnt_lo <= lo_d;
            cnt_hi <= hi_d;
        end
    end

    // R8: a disabled low counter keeps its value
    a_r8_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lo && !zero_cmd) |=> (cnt_lo == $past(cnt_lo)));

    // R3: wrap from all ones to zero when clear-on-match is not taken
    a_r3_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo && !zero_cmd && (cnt_lo == '1) && !clr_lo) |=> (cnt_lo == '0));

    // R5: chained high counter does not move without a queued step
    a_r5_no_stray_step: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && (state_q == CQ_IDLE) && !zero_cmd) |=> (cnt_hi == $past(cnt_hi)));

    // R11: counter-zero empties the queue
    a_r11_zero_drops_queue: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cmd |=> (state_q == CQ_IDLE));

endmodule

// File: rtl/wkt_stamp.sv
module wkt_stamp #(
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               zero_cmd,
    input  logic               en,
    output logic [STAMP_W-1:0] cnt,
    output logic               wrap_hit
);

    localparam logic [STAMP_W-1:0] ONE = STAMP_W'(1);

    assign wrap_hit = en && !zero_cmd && (cnt == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (zero_cmd) cnt <= '0;
        else if (en)       cnt <= cnt + ONE;
    end

    // R7: one step per enabled clock
    a_r7_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !zero_cmd) |=> (cnt == STAMP_W'($past(cnt) + ONE)));

    // R8: disabled stamp holds
    a_r8_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !zero_cmd) |=> $stable(cnt));

endmodule

// File: rtl/wkt_flags.sv
module wkt_flags
    import wkt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] hits,
    input  logic [NUM_CNT-1:0] ie,
    input  logic [NUM_CNT-1:0] flag_clr,
    input  logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] flags,
    output logic               irq
);

    logic [NUM_CNT-1:0] set_v;

    assign set_v = hits & ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | set_v;
    end

    assign irq = |(flags & mask);

    // R9: without a clear, no flag falls
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr == '0) |=> ((flags & $past(flags)) == $past(flags)));

    // R9: without an enabled event, no flag rises
    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v == '0) |=> ((flags & ~$past(flags)) == '0));

endmodule

// File: rtl/wkt_top.sv
module wkt_top
    import wkt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt_lo,
    output logic [CNT_W-1:0]   cnt_hi,
    output logic [STAMP_W-1:0] cnt_stamp,
    output logic [2:0]         irq_flags,
    output logic               irq
);

    wkt_ctrl_t          ctrl;
    logic [CNT_W-1:0]   match_lo, match_hi;
    logic [NUM_CNT-1:0] irq_mask, flag_clr, hits, ie;
    logic               zero_cmd, hit_lo, hit_hi, hit_st;

    wkt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .match_lo(match_lo), .match_hi(match_hi),
        .ctrl(ctrl), .irq_mask(irq_mask), .flag_clr(flag_clr),
        .zero_cmd(zero_cmd)
    );

    wkt_pair #(.CNT_W(CNT_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .zero_cmd(zero_cmd),
        .en_lo(ctrl.en0), .en_hi(ctrl.en1), .clr_lo(ctrl.clr0),
        .clr_hi(ctrl.clr1), .chain(ctrl.chain),
        .match_lo(match_lo), .match_hi(match_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .hit_lo(hit_lo), .hit_hi(hit_hi)
    );

    wkt_stamp #(.STAMP_W(STAMP_W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .zero_cmd(zero_cmd), .en(ctrl.en2),
        .cnt(cnt_stamp), .wrap_hit(hit_st)
    );

    assign hits = {hit_st, hit_hi, hit_lo};
    assign ie   = {ctrl.ie2, ctrl.ie1, ctrl.ie0};

    wkt_flags u_flags (
        .clk(clk), .rst_n(rst_n), .hits(hits), .ie(ie), .flag_clr(flag_clr),
        .mask(irq_mask), .flags(irq_flags), .irq(irq)
    );

    // R10: a masked-off flag set alone never drives the interrupt
    a_r10_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

endmodule

// File: tb/wkt_top_tb.sv
module wkt_top_tb;

    localparam int CW = 16;
    localparam int SW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] cnt_lo, cnt_hi;
    logic [SW-1:0] cnt_stamp;
    logic [2:0]    irq_flags;
    logic          irq;

    int checks = 0;
    int errors = 0;

    // model state
    logic [CW-1:0] m_c0, m_c1, m_m0, m_m1;
    logic [SW-1:0] m_c2;
    logic [8:0]    m_ctrl;
    logic [2:0]    m_mask, m_fl;
    logic          m_pend;

    always #10 clk = ~clk;

    wkt_top #(.CNT_W(CW), .STAMP_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .cnt_stamp(cnt_stamp), .irq_flags(irq_flags), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic expect_irq();
        return |(m_fl & m_mask);
    endfunction

    task automatic model_step(input bit we, input logic [2:0] a, input logic [CW-1:0] d);
        logic zc, ev0, ev1, ev2, adv1;
        logic [CW-1:0] s1;
        logic [2:0] fclr;
        zc   = we && (a == 3'd5);
        fclr = (we && (a == 3'd4)) ? d[2:0] : 3'b000;
        ev0  = m_ctrl[0] && !zc && (m_c0 == m_m0);
        adv1 = !zc && m_ctrl[1] && (m_ctrl[8] ? m_pend : 1'b1);
        s1   = (m_ctrl[4] && (m_c1 == m_m1)) ? '0 : m_c1 + 16'd1;
        ev1  = adv1 && (s1 == m_m1);
        ev2  = m_ctrl[2] && !zc && (m_c2 == '1);
        m_fl = (m_fl & ~fclr) | ({ev2, ev1, ev0} & m_ctrl[7:5]);
        m_pend = ev0 && m_ctrl[8];
        if (zc) begin
            m_c0 = '0; m_c1 = '0; m_c2 = '0;
        end else begin
            if (m_ctrl[0]) m_c0 = (ev0 && m_ctrl[3]) ? '0 : m_c0 + 16'd1;
            if (adv1)      m_c1 = s1;
            if (m_ctrl[2]) m_c2 = m_c2 + 1'b1;
        end
        if (we) begin
            case (a)
                3'd0: m_m0 = d;
                3'd1: m_m1 = d;
                3'd2: m_ctrl = d[8:0];
                3'd3: m_mask = d[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic tick(input bit we, input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        model_step(we, a, d);
        @(negedge clk);
        chk("R3 low count", 32'(cnt_lo), 32'(m_c0));
        chk("R5 high count", 32'(cnt_hi), 32'(m_c1));
        chk("R7 stamp count", 32'(cnt_stamp), 32'(m_c2));
        chk("R9 flags", 32'(irq_flags), 32'(m_fl));
        chk("R10 irq", 32'(irq), 32'(expect_irq()));
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        tick(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 3'd0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        m_c0 = '0; m_c1 = '0; m_c2 = '0; m_m0 = '1; m_m1 = '1;
        m_ctrl = '0; m_mask = '0; m_fl = '0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 low zero", 32'(cnt_lo), 0);
        chk("R1 high zero", 32'(cnt_hi), 0);
        chk("R1 stamp zero", 32'(cnt_stamp), 0);
        chk("R1 flags zero", 32'(irq_flags), 0);
        chk("R1 irq low", 32'(irq), 0);

        // R5 chained delay with R4 low clear-on-match
        wr(3'd0, 16'd3); wr(3'd1, 16'd2); wr(3'd3, 16'd2); wr(3'd5, 16'd0);
        wr(3'd2, 16'h014B);
        idle(4);
        chk("R4 low cleared on match", 32'(cnt_lo), 0);
        chk("R5 high not yet stepped", 32'(cnt_hi), 0);
        idle(1);
        chk("R5 step lands one tick after match", 32'(cnt_hi), 1);
        idle(3);
        chk("R5 high holds between matches", 32'(cnt_hi), 1);
        chk("R5 no irq before deadline", 32'(irq), 0);
        idle(1);
        chk("R5 high reaches match", 32'(cnt_hi), 2);
        chk("R5 irq at deadline", 32'(irq), 1);

        // R6 free-running high counter with clear-on-match
        wr(3'd2, 16'd0); wr(3'd4, 16'd7); wr(3'd5, 16'd0); wr(3'd1, 16'd4);
        wr(3'd2, 16'h0052);
        idle(3);
        chk("R6 high counts alone", 32'(cnt_hi), 3);
        chk("R6 no flag before match", 32'(irq_flags), 0);
        idle(1);
        chk("R6 high lands on match", 32'(cnt_hi), 4);
        chk("R6 high flag", 32'(irq_flags), 2);
        idle(1);
        chk("R6 high cleared after match", 32'(cnt_hi), 0);
        chk("R9 flag sticky", 32'(irq_flags), 2);
        wr(3'd3, 16'd0);
        chk("R10 masked flag no irq", 32'(irq), 0);
        wr(3'd3, 16'd2);
        chk("R10 unmasked flag irq", 32'(irq), 1);
        wr(3'd4, 16'd2);
        chk("R9 flag cleared", 32'(irq_flags & 3'b010), 0);

        // R8 disabled low counter sitting on its match
        wr(3'd2, 16'd0); wr(3'd4, 16'd7); wr(3'd0, 16'd0); wr(3'd5, 16'd0);
        wr(3'd2, 16'h0022);
        idle(5);
        chk("R8 disabled low holds", 32'(cnt_lo), 0);
        chk("R8 disabled low no event", 32'(irq_flags), 0);

        // R11 counter-zero command
        wr(3'd2, 16'h0007);
        idle(10);
        wr(3'd5, 16'd0);
        chk("R11 zero low", 32'(cnt_lo), 0);
        chk("R11 zero high", 32'(cnt_hi), 0);
        chk("R11 zero stamp", 32'(cnt_stamp), 0);

        // R7 stamp rollover
        wr(3'd2, 16'd0); wr(3'd4, 16'd7); wr(3'd3, 16'd4); wr(3'd5, 16'd0);
        wr(3'd2, 16'h0084);
        idle((1 << SW) - 1);
        chk("R7 stamp at all ones", 32'(cnt_stamp), 32'((1 << SW) - 1));
        chk("R7 no event before rollover", 32'(irq_flags), 0);
        idle(1);
        chk("R7 stamp rolled", 32'(cnt_stamp), 0);
        chk("R7 rollover flag", 32'(irq_flags), 4);

        // R3 low passes match and wraps
        wr(3'd2, 16'd0); wr(3'd4, 16'd7); wr(3'd0, 16'd5); wr(3'd3, 16'd1);
        wr(3'd5, 16'd0); wr(3'd2, 16'h0021);
        idle(5);
        chk("R3 low at match", 32'(cnt_lo), 5);
        idle(1);
        chk("R3 low passes match", 32'(cnt_lo), 6);
        chk("R3 low event flag", 32'(irq_flags), 1);
        idle(65529);
        chk("R3 low at top", 32'(cnt_lo), 32'hFFFF);
        idle(1);
        chk("R3 low wraps", 32'(cnt_lo), 0);
        wr(3'd6, 16'h01FF);
        chk("R2 unused address leaves control", 32'(cnt_lo), 1);
        idle(1);
        chk("R2 low still enabled", 32'(cnt_lo), 2);

        // random mix, every cycle compared with the model
        for (int i = 0; i < 25000; i++) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0) begin
                int k;
                logic [2:0] a;
                logic [CW-1:0] d;
                k = int'($urandom % 16);
                if (k < 3)       begin a = 3'd0; d = CW'($urandom % 24); end
                else if (k < 6)  begin a = 3'd1; d = CW'($urandom % 24); end
                else if (k < 10) begin a = 3'd2; d = CW'($urandom % 512); end
                else if (k < 12) begin a = 3'd3; d = CW'($urandom % 8); end
                else if (k < 14) begin a = 3'd4; d = CW'($urandom % 8); end
                else if (k < 15) begin a = 3'd5; d = CW'($urandom); end
                else             begin a = 3'd6; d = CW'($urandom); end
                wr(a, d);
            end else begin
                idle(1);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule